// File: doc/BRIEF.md
# Multi-Phase PWM Timebase

This block produces the common time base that phase comparators of a multi-phase pulse-width modulator compare against. A programmable divider turns the system clock into a slower count tick, and a 5-bit counter advances once per tick. The counter restarts either on its own, when it reaches a programmed terminal value, or on an external synchronisation edge. The block reports the current count, a one-clock tick strobe and a one-clock period-boundary strobe.

As a master, the block drives a sync output that is high for the last tick period of every PWM period. Other instances can follow that output as slaves. A slave counts at the same tick rate and is restarted by each rising edge on its sync input. It also stays parked at zero after being enabled until the first such edge arrives. Two run enables, one per phase, gate the whole time base. While both are low, the counter and the divider are held cleared.

The divide select and the terminal count are captured into working copies only at a period boundary, or while the counter is held. A change therefore never shortens or stretches the period that is already in progress.

Top module: `pwm_timebase`

## Requirements
- R1: While running, `tick` pulses for one clock every 2^`div_sel` clocks. After the counter leaves a held state or is restarted, the first tick comes a full 2^`div_sel` clocks later.
- R2: In master mode, `count` steps 0,1,...,P and then returns to 0, advancing by one on each tick. P is the captured terminal value. The PWM period is therefore 2^`div_sel`×(P+1) clocks. `period_end` is high for one clock, on the tick that returns the count to 0.
- R3: A terminal value of 0 on `per_val` is captured as 1, so the shortest period is two ticks.
- R4: In master mode, `sync_out` is high exactly while `count` equals P, which lasts 2^`div_sel` clocks in each period. In slave mode, `sync_out` stays low.
- R5: While `run_a` and `run_b` are both low, `count` is 0 and `tick`, `period_end` and `sync_out` stay low.
- R6: In slave mode, once enabled, `count` stays at 0 and no tick occurs until the first rising edge of `sync_in` has passed the synchroniser.
- R7: In slave mode, a rising edge of `sync_in` passes two synchroniser flops and then an edge detector. If `sync_in` goes high just before clock edge k, then `period_end` is high in the cycle after edge k+1, and the counter and divider restart at 0 on edge k+2. A sync pulse of any length causes a single restart.
- R8: A new `per_val` or `div_sel` takes effect only at the next period boundary (a wrap or a restart), or at once while the counter is held.
- R9: After reset, `count` is 0 and `tick`, `period_end` and `sync_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_a | input | 1 | Run enable for the first phase |
| run_b | input | 1 | Run enable for the second phase |
| slave_mode | input | 1 | 1: follow `sync_in`; 0: master |
| div_sel | input | 2 | Tick divide select; divides by 2^div_sel |
| per_val | input | 5 | Terminal count P (0 is treated as 1) |
| sync_in | input | 1 | External sync, asynchronous |
| count | output | 5 | Current period count |
| tick | output | 1 | One-clock pulse per count tick |
| period_end | output | 1 | One-clock pulse at each period boundary |
| sync_out | output | 1 | High during the last tick period (master) |

## Verification
The hardest situation to reach is a slave that has already been armed and is then restarted in the middle of a count. This has to coincide with a long sync pulse, and it has to stay apart from the arming edge and from the slave's own wrap. The bench arms a slave with one long pulse and lets it count well below a large terminal value. It then raises `sync_in` again for many clocks. It counts the clocks from the rise to `period_end`, and it counts the period boundaries inside the pulse window. A reference model that steps alongside the design is compared on every clock. This catches any off-by-one in the synchroniser depth, in the deferred capture of the configuration, or in the first tick after a release.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W       = 5,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_a,
  input  logic             run_b,
  input  logic             slave_mode,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [CNT_W-1:0] per_val,
  input  logic             sync_in,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             period_end,
  output logic             sync_out
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0]     cnt_q, per_q;
  logic [DIV_W-1:0]     div_q;
  logic [PRE_W-1:0]     pre_q, pre_lim;
  logic                 armed_q;
  logic [SYNC_STAGES:0] sy_q;

  wire enabled   = run_a | run_b;
  wire sync_rise = sy_q[SYNC_STAGES-1] & ~sy_q[SYNC_STAGES];
  wire held      = ~enabled | (slave_mode & ~armed_q);

  assign pre_lim = PRE_W'((32'd1 << div_q) - 32'd1);

  wire tick_w  = ~held & (pre_q == pre_lim);
  wire at_top  = (cnt_q == per_q);
  wire wrap    = tick_w & at_top;
  wire restart = ~held & slave_mode & sync_rise;
  wire bound   = wrap | restart;

  wire [CNT_W-1:0] per_safe = (per_val == '0) ? CNT_W'(1) : per_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q    <= '0;
      armed_q <= 1'b0;
      per_q   <= CNT_W'(1);
      div_q   <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      sy_q <= {sy_q[SYNC_STAGES-1:0], sync_in};

      if (!enabled || !slave_mode) armed_q <= 1'b0;
      else if (sync_rise)          armed_q <= 1'b1;

      if (held || bound) begin
        per_q <= per_safe;
        div_q <= div_sel;
      end

      if (held || restart) begin
        cnt_q <= '0;
        pre_q <= '0;
      end else if (tick_w) begin
        pre_q <= '0;
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign count      = cnt_q;
  assign tick       = tick_w;
  assign period_end = bound;
  assign sync_out   = ~held & ~slave_mode & at_top;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 5,
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_a,
  input logic             run_b,
  input logic             slave_mode,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             period_end,
  input logic             sync_out,
  input logic [CNT_W-1:0] per_q,
  input logic [DIV_W-1:0] div_q
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_a || run_b) |=> count == '0); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_a || run_b) |-> !tick && !period_end && !sync_out); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !period_end) |=> count == $past(count) + 1'b1); // R2
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_a || run_b) && !tick && !period_end) |=> $stable(count)); // R2
  AST_BOUND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> count == '0); // R7
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !sync_out); // R4
  AST_CFG_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !period_end) |=> $stable(per_q) && $stable(div_q)); // R8
  AST_PER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    per_q != '0); // R3
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_a(run_a), .run_b(run_b),
  .slave_mode(slave_mode), .count(count), .tick(tick),
  .period_end(period_end), .sync_out(sync_out),
  .per_q(per_q), .div_q(div_q)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_a = 1'b0, run_b = 1'b0, slave_mode = 1'b0, sync_in = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [4:0] per_val = 5'd3;
  logic [4:0] count;
  logic       tick, period_end, sync_out;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .run_a(run_a), .run_b(run_b),
    .slave_mode(slave_mode), .div_sel(div_sel), .per_val(per_val),
    .sync_in(sync_in), .count(count), .tick(tick),
    .period_end(period_end), .sync_out(sync_out)
  );

  // reference model state
  int m_cnt, m_pre, m_per, m_div;
  bit m_armed;
  bit s0, s1, s2;

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_per = 1; m_div = 0; m_armed = 0;
      s0 = 0; s1 = 0; s2 = 0;
    end else begin
      bit en, held, rise, e_tick, top, wrap, rst_ev, e_pe, e_so;
      en     = run_a || run_b;
      rise   = s1 && !s2;
      held   = !en || (slave_mode && !m_armed);
      e_tick = !held && (m_pre == (2 ** m_div) - 1);
      top    = (m_cnt == m_per);
      wrap   = e_tick && top;
      rst_ev = !held && slave_mode && rise;
      e_pe   = wrap || rst_ev;
      e_so   = !held && !slave_mode && top;
      chk(cur_req, int'(count), m_cnt, "count");
      chk(cur_req, int'(tick), int'(e_tick), "tick");
      chk(cur_req, int'(period_end), int'(e_pe), "period_end");
      chk(cur_req, int'(sync_out), int'(e_so), "sync_out");
      if (!en || !slave_mode) m_armed = 0;
      else if (rise) m_armed = 1;
      if (held || e_pe) begin
        m_per = (per_val == 0) ? 1 : int'(per_val);
        m_div = int'(div_sel);
      end
      if (held || rst_ev) begin
        m_cnt = 0; m_pre = 0;
      end else if (e_tick) begin
        m_pre = 0;
        m_cnt = top ? 0 : m_cnt + 1;
      end else begin
        m_pre = m_pre + 1;
      end
      s2 = s1; s1 = s0; s0 = sync_in;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wait_pe();
    do @(negedge clk); while (!period_end);
  endtask

  task automatic clocks_to_pe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!period_end);
  endtask

  task automatic measure_period(input int exp_v, input string req);
    int n;
    wait_pe();
    clocks_to_pe(n);
    chk(req, n, exp_v, "period length");
  endtask

  initial begin
    int n;
    #1;
    step(3);
    chk("R9", int'(count), 0, "reset count");
    chk("R9", int'(tick), 0, "reset tick");
    chk("R9", int'(period_end), 0, "reset period_end");
    chk("R9", int'(sync_out), 0, "reset sync_out");
    rst_n = 1'b1;
    step(2);

    cur_req = "R2";
    run_a = 1'b1;
    measure_period(4, "R2");
    measure_period(4, "R2");

    cur_req = "R8";
    wait_pe();
    step(1);
    per_val = 5'd7;
    clocks_to_pe(n);
    chk("R8", n, 4, "old period kept");
    clocks_to_pe(n);
    chk("R8", n, 8, "new period applied");

    cur_req = "R1";
    run_a = 1'b0;
    div_sel = 2'd2; per_val = 5'd5;
    step(4);
    chk("R5", int'(count), 0, "count while disabled");
    run_b = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
    chk("R1", n, 4, "first tick after release");
    measure_period(24, "R1");

    cur_req = "R4";
    do @(negedge clk); while (sync_out);
    do @(negedge clk); while (!sync_out);
    n = 0;
    do begin @(negedge clk); n++; end while (sync_out);
    chk("R4", n, 4, "sync_out width");

    cur_req = "R3";
    wait_pe();
    step(1);
    per_val = 5'd0; div_sel = 2'd1;
    measure_period(4, "R3");
    measure_period(4, "R3");

    cur_req = "R5";
    run_b = 1'b0;
    step(10);
    chk("R5", int'(count), 0, "held count");

    cur_req = "R6";
    slave_mode = 1'b1; div_sel = 2'd0; per_val = 5'd31;
    run_a = 1'b1;
    step(20);
    chk("R6", int'(count), 0, "slave parked");
    sync_in = 1'b1;
    step(8);
    sync_in = 1'b0;
    step(6);
    chk("R6", int'(count != 0), 1, "slave counting after arm");

    cur_req = "R7";
    step(5);
    sync_in = 1'b1;
    clocks_to_pe(n);
    chk("R7", n, 3, "restart latency");
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (period_end) n++;
    end
    chk("R7", n, 0, "single restart per pulse");
    step(1);
    sync_in = 1'b0;
    step(10);
    chk("R4", int'(sync_out), 0, "slave sync_out low");

    cur_req = "R2";
    slave_mode = 1'b0; div_sel = 2'd3; per_val = 5'd2;
    measure_period(24, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule